// File: doc/BRIEF.md
# MSI Doorbell Frame

This block is a memory-mapped frame that turns message-signaled interrupt writes into shared peripheral interrupt (SPI) edges. A requester writes a 32-bit word into the frame. When the write resolves to an SPI number inside the range assigned to the frame, the matching output line pulses high for exactly one clock cycle. An interrupt distributor downstream treats that pulse as a rising edge.

A parameter picks one of three decode modes:
- **Absolute.** The doorbell word holds the SPI number.
- **Relative.** The doorbell word holds an index, and the frame adds a fixed offset to it. The offset is either the range base or the constant 32.
- **Address.** The SPI number is derived from where in an 8 KiB window the write lands, and the data is ignored.

Two read-only registers let software find the assigned range and identify the frame. Output line `i` stands for SPI `BASE_SPI + i`.

Top module: `msi_spi_frame`

## Requirements
- R1: A read at byte offset 0x008 returns the range register. Bits [25:16] hold the base SPI, bits [9:0] hold the SPI count, and bits [31:26] and [15:10] are zero.
- R2: A read at byte offset 0xFCC returns the `IDENT` parameter.
- R3: Reads at any other offset return zero. Writes to the read-only offsets leave their read values unchanged and, outside address mode, raise no line.
- R4: In absolute mode (`MODE`=0), a full-word write to offset 0x040 signals the SPI number held in the write data. Writes to other offsets raise no line.
- R5: In relative mode (`MODE`=1), the write data plus an offset is signalled. The offset is the base SPI when `OFFSET_SEL`=0 and 32 when `OFFSET_SEL`=1.
- R6: In address mode (`MODE`=2), every full-word write in the 8 KiB window signals SPI 32 + (byte offset >> 3) and the data is ignored. In the other modes the window is 4 KiB, so addresses with bit 12 set decode nothing.
- R7: A write whose resolved SPI lies below `BASE_SPI` or above `BASE_SPI+NUM_SPI-1` raises no line.
- R8: A write with any byte strobe clear, and any cycle without write enable, raises no line.
- R9: Full-word doorbells on consecutive cycles each produce their own pulse, one per cycle.
- R10: A configuration with base below 32, count of zero, or base plus count above 1019 never raises a line.
- R11: All lines are low during and right after reset. An accepted doorbell raises exactly one line (line = SPI - `BASE_SPI`) for one cycle, on the clock edge that samples the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 13 | Byte offset within the frame |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte write strobes |
| bus_we | input | 1 | Write enable for the current cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| spi_pulse | output | NUM_SPI | One line per assigned SPI, pulsed for one cycle |

## Verification
The only state in this block is the registered pulse vector, so a wrong internal value appears on `spi_pulse` one edge after the write that caused it. That wrong value can be the wrong line, two lines at once, a pulse that lingers, or a pulse that should have been dropped. The bench predicts every cycle's vector for five differently configured frames that share one bus. Any decode, offset or range slip therefore shows as a mismatch on the very next cycle. Register read values are combinational and are checked in the same cycle the address is presented.

// File: rtl/msi_spi_frame.sv
module msi_spi_frame #(
  parameter int          MODE       = 0,
  parameter int          BASE_SPI   = 64,
  parameter int          NUM_SPI    = 32,
  parameter int          OFFSET_SEL = 0,
  parameter logic [31:0] IDENT      = 32'h0002_0A51
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [12:0]                          bus_addr,
  input  logic [31:0]                          bus_wdata,
  input  logic [3:0]                           bus_wstrb,
  input  logic                                 bus_we,
  output logic [31:0]                          bus_rdata,
  output logic [(NUM_SPI > 0 ? NUM_SPI : 1)-1:0] spi_pulse
);
  localparam int          LINES     = (NUM_SPI > 0) ? NUM_SPI : 1;
  localparam logic [12:0] RANGE_OFF = 13'h008;
  localparam logic [12:0] BELL_OFF  = 13'h040;
  localparam logic [12:0] IDENT_OFF = 13'hFCC;
  localparam int          LOW_SPI   = 32;
  localparam int          HIGH_SPI  = 1019;
  localparam bit          CFG_OK    = (BASE_SPI >= LOW_SPI) && (NUM_SPI != 0) &&
                                      (BASE_SPI + NUM_SPI <= HIGH_SPI);
  localparam int          REL_OFF   = (OFFSET_SEL != 0) ? LOW_SPI : BASE_SPI;
  localparam logic [33:0] LO_BOUND  = 34'(BASE_SPI);
  localparam logic [33:0] HI_BOUND  = 34'(BASE_SPI + NUM_SPI);

  logic [31:0] range_word;
  logic [33:0] spi_num;
  logic [33:0] line_idx;
  logic        bell_hit;
  logic        in_range;
  logic        accept;

  assign range_word = {6'b0, 10'(BASE_SPI), 6'b0, 10'(NUM_SPI)};

  assign bus_rdata = (bus_addr == RANGE_OFF) ? range_word :
                     (bus_addr == IDENT_OFF) ? IDENT      : 32'h0;

  always_comb begin
    case (MODE)
      2:       spi_num = 34'(LOW_SPI) + {24'b0, bus_addr[12:3]};
      1:       spi_num = {2'b0, bus_wdata} + 34'(REL_OFF);
      default: spi_num = {2'b0, bus_wdata};
    endcase
  end

  assign bell_hit = (MODE == 2) ? 1'b1 : (bus_addr == BELL_OFF);
  assign in_range = (spi_num >= LO_BOUND) && (spi_num < HI_BOUND);
  assign accept   = CFG_OK && bus_we && (&bus_wstrb) && bell_hit && in_range;
  assign line_idx = spi_num - LO_BOUND;

  always_ff @(posedge clk) begin
    if (!rst_n)
      spi_pulse <= '0;
    else if (accept)
      spi_pulse <= LINES'(1) << line_idx;
    else
      spi_pulse <= '0;
  end

  assert_single_line_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(spi_pulse));

  assert_strobe_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_wstrb != 4'hF) |=> (spi_pulse == '0));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> (spi_pulse == '0));

  assert_range_rsvd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == RANGE_OFF) |-> (bus_rdata[31:26] == 6'b0 && bus_rdata[15:10] == 6'b0));

  generate
    if (MODE != 2) begin : g_bell_chk
      assert_bell_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_pulse != '0) |-> $past(bus_we && bus_addr == BELL_OFF));
    end
  endgenerate
endmodule

// File: tb/msi_spi_frame_test.sv
module msi_spi_frame_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [12:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        we = 1'b0;
  logic [31:0] rd [N];
  logic [31:0] p  [N];

  int cfg_mode [N] = '{0, 1, 1, 2, 0};
  int cfg_base [N] = '{64, 100, 40, 40, 16};
  int cfg_osel [N] = '{0, 0, 1, 0, 0};

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [N-1:0][31:0] exp_q [$];
  string tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_spi_frame #(.MODE(0), .BASE_SPI(64), .NUM_SPI(32)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_wstrb(wstrb),
    .bus_we(we), .bus_rdata(rd[0]), .spi_pulse(p[0]));
  msi_spi_frame #(.MODE(1), .BASE_SPI(100), .NUM_SPI(32), .OFFSET_SEL(0)) u_relb (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_wstrb(wstrb),
    .bus_we(we), .bus_rdata(rd[1]), .spi_pulse(p[1]));
  msi_spi_frame #(.MODE(1), .BASE_SPI(40), .NUM_SPI(32), .OFFSET_SEL(1)) u_rel32 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_wstrb(wstrb),
    .bus_we(we), .bus_rdata(rd[2]), .spi_pulse(p[2]));
  msi_spi_frame #(.MODE(2), .BASE_SPI(40), .NUM_SPI(32)) u_addr (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_wstrb(wstrb),
    .bus_we(we), .bus_rdata(rd[3]), .spi_pulse(p[3]));
  msi_spi_frame #(.MODE(0), .BASE_SPI(16), .NUM_SPI(32)) u_bad (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_wstrb(wstrb),
    .bus_we(we), .bus_rdata(rd[4]), .spi_pulse(p[4]));

  function automatic logic [31:0] model(int i, logic [12:0] a, logic [31:0] d,
                                        logic [3:0] s, logic w);
    longint spi;
    bit ok;
    ok = (cfg_base[i] >= 32) && (cfg_base[i] + 32 <= 1019);
    if (!w || s != 4'hF || !ok) return 32'h0;
    if (cfg_mode[i] == 2) begin
      spi = 32 + longint'(a >> 3);
    end else begin
      if (a != 13'h040) return 32'h0;
      spi = longint'(d);
      if (cfg_mode[i] == 1) spi += (cfg_osel[i] != 0) ? 32 : cfg_base[i];
    end
    if (spi < cfg_base[i] || spi >= cfg_base[i] + 32) return 32'h0;
    return 32'd1 << (spi - cfg_base[i]);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic cyc(logic w, logic [12:0] a, logic [31:0] d, logic [3:0] s, string tag);
    logic [N-1:0][31:0] item;
    @(negedge clk);
    we = w; addr = a; wdata = d; wstrb = s;
    for (int i = 0; i < N; i++) item[i] = model(i, a, d, s, w);
    exp_q.push_back(item);
    tag_q.push_back(tag);
  endtask

  task automatic rdchk(int i, logic [12:0] a, logic [31:0] expv, string tag);
    cyc(1'b0, a, 32'h0, 4'h0, tag);
    #1;
    chk(tag, $sformatf("read inst%0d @%h", i, a), rd[i], expv);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin : monitor
    logic [N-1:0][31:0] item;
    string tag;
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && exp_q.size() > 0) begin
        item = exp_q.pop_front();
        tag = tag_q.pop_front();
        for (int i = 0; i < N; i++)
          chk(tag, $sformatf("pulse inst%0d", i), p[i], item[i]);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: all requirements, actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin : driver
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++) chk("R11", $sformatf("reset inst%0d", i), p[i], 32'h0);
    rst_n = 1'b1;
    cyc(1'b0, 13'h0, 32'h0, 4'h0, "R11");

    rdchk(0, 13'h008, 32'h0040_0020, "R1");
    rdchk(3, 13'h008, 32'h0028_0020, "R1");
    rdchk(4, 13'h008, 32'h0010_0020, "R1");
    rdchk(0, 13'hFCC, 32'h0002_0A51, "R2");
    rdchk(1, 13'hFCC, 32'h0002_0A51, "R2");
    rdchk(0, 13'h010, 32'h0, "R3");
    rdchk(0, 13'h1008, 32'h0, "R3");
    cyc(1'b1, 13'h008, 32'hFFFF_FFFF, 4'hF, "R3");
    rdchk(0, 13'h008, 32'h0040_0020, "R3");

    cyc(1'b1, 13'h040, 32'd70, 4'hF, "R4");
    cyc(1'b0, 13'h040, 32'd70, 4'hF, "R8");
    cyc(1'b1, 13'h040, 32'd64, 4'hF, "R4");
    cyc(1'b1, 13'h040, 32'd95, 4'hF, "R9");
    cyc(1'b1, 13'h040, 32'd63, 4'hF, "R7");
    cyc(1'b1, 13'h040, 32'd96, 4'hF, "R7");
    cyc(1'b1, 13'h044, 32'd70, 4'hF, "R4");
    cyc(1'b1, 13'h1040, 32'd70, 4'hF, "R6");
    cyc(1'b1, 13'h040, 32'd70, 4'h7, "R8");
    cyc(1'b1, 13'h040, 32'd5, 4'hF, "R5");
    cyc(1'b1, 13'h040, 32'd31, 4'hF, "R5");
    cyc(1'b1, 13'h040, 32'd32, 4'hF, "R7");
    cyc(1'b1, 13'h040, 32'd8, 4'hF, "R5");
    cyc(1'b1, 13'h040, 32'd39, 4'hF, "R5");
    cyc(1'b1, 13'h040, 32'hFFFF_FFFF, 4'hF, "R7");
    cyc(1'b1, 13'h040, 32'd20, 4'hF, "R10");
    cyc(1'b1, 13'h148, 32'h1234_5678, 4'hF, "R6");
    cyc(1'b1, 13'h138, 32'h0, 4'hF, "R6");
    cyc(1'b1, 13'h140, 32'h0, 4'hF, "R7");
    cyc(1'b1, 13'h1FF8, 32'h0, 4'hF, "R7");
    cyc(1'b1, 13'h0FCC, 32'h0, 4'hF, "R6");
    cyc(1'b1, 13'h0040, 32'h0, 4'hE, "R8");
    for (int k = 0; k < 4; k++) cyc(1'b1, 13'(13'h040 + 8 * k), 32'(64 + k), 4'hF, "R9");

    lf = 32'hACE1_0001;
    for (int k = 0; k < 60; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (lf[3])
        cyc(1'b1, 13'h040, {26'b0, lf[13:8]} + 32'd40, 4'hF, "R4");
      else
        cyc(lf[4], {4'b0, lf[16:9], 1'b0, lf[21:20], 1'b0} | 13'h040, {25'b0, lf[30:24]},
            lf[5] ? 4'hF : lf[7:4], "R7");
    end
    cyc(1'b0, 13'h0, 32'h0, 4'h0, "R11");
    cyc(1'b0, 13'h0, 32'h0, 4'h0, "R11");

    while (exp_q.size() > 0) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule